// File: doc/BRIEF.md
# Secondary Interrupt Collector Bank

The bank gathers up to a parameterised number of single-bit event sources and turns them into two independent interrupt requests. Each source passes through a two-flop synchroniser and an edge detector. A shared edge-select register sets whether a rising edge, a falling edge, both or neither of them count as an event. Every detected event is recorded in two status registers, one for each output line. Each line has its own mask register, so two hosts can each own one line and service the sources they care about.

All configuration and status is reached through a byte-wide register port with separate read and write strobes. A control byte chooses how status bits are acknowledged: by reading them (clear-on-read) or by writing ones to them (write-one-to-clear). It can also switch on a one-deep per-bit buffer, which keeps an event that arrives while its status bit is still set. Each line drives an active-low request pin and an active-high bit in a primary summary vector, at the position given to this bank.

Top module: `sib_bank`

Register layout, with NB = ceil(NUM_SRC/8) and EB = ceil(2*NUM_SRC/8), all multi-byte fields least significant byte first: line 0 status at 0, line 0 mask at NB, line 1 status at 2*NB, line 1 mask at 3*NB, edge select at 4*NB, control at 4*NB+EB.

## Requirements
- R1: After reset all status bits are 0, every implemented mask bit is 1, the edge-select and control bytes read 0, and both irq_n outputs are high.
- R2: A read strobe at a clock edge returns the addressed byte on reg_rdata right after that edge, and reg_rdata is 0 after any edge without a read strobe.
- R3: Source i is configured in edge byte 4*NB + i/4: bit 2*(i mod 4)+1 enables rising edges and bit 2*(i mod 4) enables falling edges. With both bits 0 the source never sets a status bit. An event on source i sets bit i mod 8 of status byte i/8.
- R4: A source change sampled at clock edge k sets its status bit at edge k+2, and not before.
- R5: Each event sets the status bit on both lines. Clearing or masking one line leaves the other line unchanged.
- R6: A mask bit of 1 keeps its status bit from reaching the line output, and the status bit still records events.
- R7: irq_n[l] is low exactly while some bit of line l has status 1 and mask 0. Bit BANK_POS of prim_l<l> is the inverse of irq_n[l], and every other bit of prim_l<l> is 0.
- R8: Control bit 0 selects clear-on-read when 1. Control bit 1 enables pending buffering when 1. The control byte reads back as written in those two bits, with all other bits 0.
- R9: In clear-on-read mode a read of a status byte clears the bits it returned, and writes to status bytes have no effect.
- R10: In write-one-to-clear mode, writing a 1 to a status bit clears it, writing a 0 leaves it, and reads do not clear it.
- R11: With buffering on, an event that arrives while its status bit is set is held and sets the bit again at the clear, so a second clear is needed. With buffering off, such an event is lost.
- R12: An event and a clear of the same status bit in the same cycle leave the bit set.
- R13: Addresses above the control byte read 0 and writes to them change nothing. Status and mask bits at or above NUM_SRC read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_in | input | NUM_SRC | Raw event sources, asynchronous to clk |
| reg_addr | input | ADDR_W | Register byte address |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Registered read data |
| irq_n | output | 2 | Active-low request, one per line |
| prim_l0 | output | PRIM_W | Primary summary for line 0, bit BANK_POS active |
| prim_l1 | output | PRIM_W | Primary summary for line 1, bit BANK_POS active |

## Verification
The bound checker watches these every cycle: a status bit never rises for a source whose edge pair is zero, a fully masked line never asserts, reads in write-one-to-clear mode never lower status, idle and out-of-range reads return zero, and the primary vectors stay one-hot and agree with the request pins. Only the bench scenarios can show the two-edge synchroniser latency, the reload of a held event after a clear, an event winning over a simultaneous clear, and the independence of the two lines. Each of these needs a set sequence of source toggles and register accesses, compared against a behavioural model on every clock.

// File: rtl/sib_pkg.sv
package sib_pkg;
    localparam int LINES         = 2;
    localparam int CTRL_COR_BIT  = 0;
    localparam int CTRL_PEND_BIT = 1;

    function automatic int byte_count(input int bits);
        return (bits + 7) / 8;
    endfunction
endpackage

// File: rtl/sib_edge.sv
module sib_edge #(
    parameter int NUM_SRC = 24
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NUM_SRC-1:0]     src_in,
    input  logic [2*NUM_SRC-1:0]   edge_cfg,
    output logic [NUM_SRC-1:0]     evt
);
    typedef struct packed {
        logic [NUM_SRC-1:0] s1;
        logic [NUM_SRC-1:0] s2;
        logic [NUM_SRC-1:0] prev;
    } sync_t;

    sync_t sync_d, sync_q;

    always_comb begin
        sync_d      = sync_q;
        sync_d.s1   = src_in;
        sync_d.s2   = sync_q.s1;
        sync_d.prev = sync_q.s2;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= sync_d;
    end

    // pair per source: upper bit = rising, lower bit = falling
    for (genvar i = 0; i < NUM_SRC; i++) begin : g_det
        assign evt[i] = (sync_q.s2[i] & ~sync_q.prev[i] & edge_cfg[2*i+1])
                      | (~sync_q.s2[i] & sync_q.prev[i] & edge_cfg[2*i]);
    end
endmodule

// File: rtl/sib_line.sv
module sib_line #(
    parameter int NUM_SRC = 24,
    parameter int ADDR_W  = 5,
    parameter int ST_BASE = 0,
    parameter int MK_BASE = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ADDR_W-1:0]  reg_addr,
    input  logic               reg_wr,
    input  logic               reg_rd,
    input  logic [7:0]         reg_wdata,
    input  logic               clr_on_rd,
    input  logic               pend_en,
    input  logic [NUM_SRC-1:0] evt,
    output logic [NUM_SRC-1:0] status_o,
    output logic [NUM_SRC-1:0] mask_o,
    output logic [7:0]         rd_byte,
    output logic               active
);
    localparam int NB = sib_pkg::byte_count(NUM_SRC);

    typedef struct packed {
        logic [NUM_SRC-1:0] st;
        logic [NUM_SRC-1:0] pd;
        logic [NUM_SRC-1:0] mk;
    } line_t;

    line_t line_d, line_q;
    logic [NUM_SRC-1:0] clr_v;
    logic st_hit, mk_hit;
    int   addr_i, sidx, midx;

    always_comb begin
        addr_i  = int'(reg_addr);
        sidx    = addr_i - ST_BASE;
        midx    = addr_i - MK_BASE;
        st_hit  = (addr_i >= ST_BASE) && (addr_i < ST_BASE + NB);
        mk_hit  = (addr_i >= MK_BASE) && (addr_i < MK_BASE + NB);
        line_d  = line_q;
        clr_v   = '0;
        rd_byte = '0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (st_hit && (i / 8 == sidx)) begin
                if (reg_rd) rd_byte[i % 8] = line_q.st[i];
                clr_v[i] = clr_on_rd ? reg_rd : (reg_wr & reg_wdata[i % 8]);
            end
            if (mk_hit && (i / 8 == midx)) begin
                if (reg_rd) rd_byte[i % 8] = line_q.mk[i];
                if (reg_wr) line_d.mk[i] = reg_wdata[i % 8];
            end
            // a new event beats the clear; a held event reloads at the clear
            if (clr_v[i]) begin
                line_d.st[i] = evt[i] | line_q.pd[i];
                line_d.pd[i] = evt[i] & line_q.pd[i];
            end else begin
                line_d.st[i] = line_q.st[i] | evt[i];
                line_d.pd[i] = line_q.pd[i] | (evt[i] & line_q.st[i] & pend_en);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            line_q.st <= '0;
            line_q.pd <= '0;
            line_q.mk <= '1;
        end else begin
            line_q <= line_d;
        end
    end

    assign status_o = line_q.st;
    assign mask_o   = line_q.mk;
    assign active   = |(line_q.st & ~line_q.mk);
endmodule

// File: rtl/sib_bank.sv
module sib_bank #(
    parameter int NUM_SRC  = 24,
    parameter int ADDR_W   = 5,
    parameter int PRIM_W   = 8,
    parameter int BANK_POS = 0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_in,
    input  logic [ADDR_W-1:0]  reg_addr,
    input  logic               reg_wr,
    input  logic               reg_rd,
    input  logic [7:0]         reg_wdata,
    output logic [7:0]         reg_rdata,
    output logic [1:0]         irq_n,
    output logic [PRIM_W-1:0]  prim_l0,
    output logic [PRIM_W-1:0]  prim_l1
);
    localparam int LINES     = sib_pkg::LINES;
    localparam int NB        = sib_pkg::byte_count(NUM_SRC);
    localparam int EB        = sib_pkg::byte_count(2 * NUM_SRC);
    localparam int EDGE_BASE = LINES * 2 * NB;
    localparam int CTRL_ADDR = EDGE_BASE + EB;

    typedef struct packed {
        logic [2*NUM_SRC-1:0] cfg;
        logic                 cor;
        logic                 pend;
        logic [7:0]           rdata;
    } top_t;

    top_t top_d, top_q;

    logic [NUM_SRC-1:0]   evt;
    logic [NUM_SRC-1:0]   line_st [LINES];
    logic [NUM_SRC-1:0]   line_mk [LINES];
    logic [7:0]           line_rb [LINES];
    logic [LINES-1:0]     line_act;
    logic [2*NUM_SRC-1:0] edge_cfg;
    logic                 clr_on_rd;
    logic                 ed_hit, ct_hit;
    logic [7:0]           edge_rb, ctrl_rb;
    int                   addr_i, eidx;

    assign edge_cfg  = top_q.cfg;
    assign clr_on_rd = top_q.cor;

    sib_edge #(.NUM_SRC(NUM_SRC)) u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .src_in   (src_in),
        .edge_cfg (edge_cfg),
        .evt      (evt)
    );

    for (genvar l = 0; l < LINES; l++) begin : g_line
        sib_line #(
            .NUM_SRC (NUM_SRC),
            .ADDR_W  (ADDR_W),
            .ST_BASE (l * 2 * NB),
            .MK_BASE (l * 2 * NB + NB)
        ) u_line (
            .clk       (clk),
            .rst_n     (rst_n),
            .reg_addr  (reg_addr),
            .reg_wr    (reg_wr),
            .reg_rd    (reg_rd),
            .reg_wdata (reg_wdata),
            .clr_on_rd (top_q.cor),
            .pend_en   (top_q.pend),
            .evt       (evt),
            .status_o  (line_st[l]),
            .mask_o    (line_mk[l]),
            .rd_byte   (line_rb[l]),
            .active    (line_act[l])
        );
    end

    always_comb begin
        addr_i  = int'(reg_addr);
        eidx    = addr_i - EDGE_BASE;
        ed_hit  = (addr_i >= EDGE_BASE) && (addr_i < CTRL_ADDR);
        ct_hit  = (addr_i == CTRL_ADDR);
        top_d   = top_q;
        edge_rb = '0;
        ctrl_rb = '0;
        for (int j = 0; j < 2 * NUM_SRC; j++) begin
            if (ed_hit && (j / 8 == eidx)) begin
                if (reg_rd) edge_rb[j % 8] = top_q.cfg[j];
                if (reg_wr) top_d.cfg[j] = reg_wdata[j % 8];
            end
        end
        if (ct_hit && reg_rd) begin
            ctrl_rb[sib_pkg::CTRL_COR_BIT]  = top_q.cor;
            ctrl_rb[sib_pkg::CTRL_PEND_BIT] = top_q.pend;
        end
        if (ct_hit && reg_wr) begin
            top_d.cor  = reg_wdata[sib_pkg::CTRL_COR_BIT];
            top_d.pend = reg_wdata[sib_pkg::CTRL_PEND_BIT];
        end
        top_d.rdata = edge_rb | ctrl_rb;
        for (int l = 0; l < LINES; l++) top_d.rdata = top_d.rdata | line_rb[l];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) top_q <= '0;
        else        top_q <= top_d;
    end

    assign reg_rdata = top_q.rdata;
    assign irq_n     = ~line_act;

    for (genvar k = 0; k < PRIM_W; k++) begin : g_prim
        if (k == BANK_POS) begin : g_hit
            assign prim_l0[k] = line_act[0];
            assign prim_l1[k] = line_act[1];
        end else begin : g_zero
            assign prim_l0[k] = 1'b0;
            assign prim_l1[k] = 1'b0;
        end
    end
endmodule

// File: rtl/sib_bank_chk.sv
module sib_bank_chk #(
    parameter int NUM_SRC   = 24,
    parameter int ADDR_W    = 5,
    parameter int PRIM_W    = 8,
    parameter int LAST_ADDR = 18
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic [ADDR_W-1:0]      reg_addr,
    input logic                   reg_rd,
    input logic                   reg_wr,
    input logic [7:0]             reg_rdata,
    input logic [1:0]             irq_n,
    input logic [PRIM_W-1:0]      prim_l0,
    input logic [PRIM_W-1:0]      prim_l1,
    input logic [NUM_SRC-1:0]     st0,
    input logic [NUM_SRC-1:0]     mk0,
    input logic [2*NUM_SRC-1:0]   cfg,
    input logic                   cor
);
    logic [NUM_SRC-1:0] en_any;
    for (genvar i = 0; i < NUM_SRC; i++) begin : g_en
        assign en_any[i] = cfg[2*i] | cfg[2*i+1];
    end

    AST_DISABLED_NEVER_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        ((st0 & ~$past(st0) & ~$past(en_any)) == '0)); // R3
    AST_FULL_MASK_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (&mk0) |-> irq_n[0]); // R6
    AST_W1C_READ_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && !reg_wr && !cor) |=> (($past(st0) & ~st0) == '0)); // R10
    AST_IDLE_RDATA_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_rd |=> (reg_rdata == 8'h00)); // R2
    AST_OOR_RDATA_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && (int'(reg_addr) > LAST_ADDR)) |=> (reg_rdata == 8'h00)); // R13
    AST_PRIM_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(prim_l0) && $onehot0(prim_l1)); // R7
    AST_PRIM_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        ((prim_l0 != '0) == !irq_n[0]) && ((prim_l1 != '0) == !irq_n[1])); // R7
endmodule

bind sib_bank sib_bank_chk #(
    .NUM_SRC   (NUM_SRC),
    .ADDR_W    (ADDR_W),
    .PRIM_W    (PRIM_W),
    .LAST_ADDR (CTRL_ADDR)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_addr  (reg_addr),
    .reg_rd    (reg_rd),
    .reg_wr    (reg_wr),
    .reg_rdata (reg_rdata),
    .irq_n     (irq_n),
    .prim_l0   (prim_l0),
    .prim_l1   (prim_l1),
    .st0       (line_st[0]),
    .mk0       (line_mk[0]),
    .cfg       (edge_cfg),
    .cor       (clr_on_rd)
);

// File: tb/sib_bank_tb.sv
module sib_bank_tb;
    localparam int N       = 20;
    localparam int AW      = 5;
    localparam int PW      = 8;
    localparam int POS     = 2;
    localparam int CLK_PER = 10;
    // map for N=20: st0 0..2, mk0 3..5, st1 6..8, mk1 9..11, edge 12..16, ctrl 17

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [N-1:0] src = '0;
    logic [AW-1:0] addr = '0;
    logic wr = 1'b0, rd = 1'b0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic [1:0] irq_n;
    logic [PW-1:0] prim_l0, prim_l1;

    int checks = 0, fails = 0;
    bit done = 1'b0;

    always #(CLK_PER/2) clk = ~clk;

    sib_bank #(.NUM_SRC(N), .ADDR_W(AW), .PRIM_W(PW), .BANK_POS(POS)) u_dut (
        .clk(clk), .rst_n(rst_n), .src_in(src), .reg_addr(addr), .reg_wr(wr),
        .reg_rd(rd), .reg_wdata(wdata), .reg_rdata(rdata), .irq_n(irq_n),
        .prim_l0(prim_l0), .prim_l1(prim_l1)
    );

    // behavioural reference
    logic [N-1:0]   m_s1, m_s2, m_pv;
    logic [N-1:0]   m_st [2];
    logic [N-1:0]   m_pd [2];
    logic [N-1:0]   m_mk [2];
    logic [2*N-1:0] m_cfg;
    logic           m_cor, m_pen;
    logic [7:0]     m_rd;

    task automatic m_reset();
        m_s1 = '0; m_s2 = '0; m_pv = '0; m_cfg = '0; m_cor = 0; m_pen = 0; m_rd = '0;
        for (int l = 0; l < 2; l++) begin m_st[l] = '0; m_pd[l] = '0; m_mk[l] = '1; end
    endtask

    function automatic logic [7:0] m_byte(input int a);
        logic [23:0] t;
        logic [39:0] e;
        t = '0; e = '0;
        if (a < 12) begin
            if (a % 6 < 3) t[N-1:0] = m_st[a / 6];
            else           t[N-1:0] = m_mk[a / 6];
            return t[(a % 3) * 8 +: 8];
        end else if (a < 17) begin
            e[2*N-1:0] = m_cfg;
            return e[(a - 12) * 8 +: 8];
        end else if (a == 17) begin
            return {6'b0, m_pen, m_cor};
        end
        return 8'h00;
    endfunction

    initial m_reset();

    always @(posedge clk) begin
        if (!rst_n) m_reset();
        else begin
            logic [N-1:0] ev;
            logic clr;
            int a;
            a = int'(addr);
            for (int i = 0; i < N; i++)
                ev[i] = (m_s2[i] && !m_pv[i] && m_cfg[2*i+1]) || (!m_s2[i] && m_pv[i] && m_cfg[2*i]);
            m_rd = rd ? m_byte(a) : 8'h00;
            for (int l = 0; l < 2; l++) begin
                for (int i = 0; i < N; i++) begin
                    clr = (a == l*6 + i/8) && (m_cor ? rd : (wr && wdata[i%8]));
                    if (clr) begin
                        if (ev[i]) m_st[l][i] = 1'b1;
                        else begin m_st[l][i] = m_pd[l][i]; m_pd[l][i] = 1'b0; end
                    end else if (ev[i]) begin
                        if (m_st[l][i] && m_pen) m_pd[l][i] = 1'b1;
                        m_st[l][i] = 1'b1;
                    end
                    if (wr && a == l*6 + 3 + i/8) m_mk[l][i] = wdata[i%8];
                end
            end
            for (int j = 0; j < 2*N; j++)
                if (wr && a == 12 + j/8) m_cfg[j] = wdata[j%8];
            if (wr && a == 17) begin m_cor = wdata[0]; m_pen = wdata[1]; end
            m_pv = m_s2; m_s2 = m_s1; m_s1 = src;
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && !done) begin
            logic [1:0] act;
            act[0] = |(m_st[0] & ~m_mk[0]);
            act[1] = |(m_st[1] & ~m_mk[1]);
            check("R7 irq_n", {30'b0, irq_n}, {30'b0, ~act});
            check("R7 prim", {prim_l1, prim_l0}, {(PW'(act[1]) << POS), (PW'(act[0]) << POS)});
            check("R2 rdata", {24'b0, rdata}, {24'b0, m_rd});
        end
    end

    task automatic wr_reg(input int a, input logic [7:0] d);
        @(negedge clk); addr = AW'(a); wdata = d; wr = 1'b1;
        @(negedge clk); wr = 1'b0;
    endtask

    task automatic rd_exp(input int a, input logic [7:0] exp, input string tag);
        @(negedge clk); addr = AW'(a); rd = 1'b1;
        @(negedge clk); rd = 1'b0;
        check(tag, {24'b0, rdata}, {24'b0, exp});
    endtask

    task automatic rd_mod(input int a, input string tag);
        @(negedge clk); addr = AW'(a); rd = 1'b1;
        @(negedge clk); rd = 1'b0;
        check(tag, {24'b0, rdata}, {24'b0, m_rd});
    endtask

    task automatic set_src(input logic [N-1:0] v);
        @(negedge clk); src = v;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        idle(1);
        check("R1 irq_n", {30'b0, irq_n}, 32'h3);
        rd_exp(3, 8'hFF, "R1 mask byte");
        rd_exp(5, 8'h0F, "R1 R13 mask top byte");
        rd_exp(17, 8'h00, "R1 ctrl");
        rd_exp(12, 8'h00, "R1 edge");

        // src0 rise, src1 fall, src2 rise, src5 both, src3 none
        wr_reg(12, 8'h26);
        wr_reg(13, 8'h0C);
        wr_reg(3, 8'h00);
        set_src(20'h00003); idle(5);
        check("R7 line0 low", {31'b0, irq_n[0]}, 32'h0);
        check("R6 line1 masked", {31'b0, irq_n[1]}, 32'h1);
        rd_exp(0, 8'h01, "R3 rise src0");
        rd_exp(0, 8'h01, "R10 read keeps");
        rd_exp(6, 8'h01, "R5 R6 line1 records");
        wr_reg(0, 8'h01);
        rd_exp(0, 8'h00, "R10 write one clears");
        rd_exp(6, 8'h01, "R5 line1 untouched");

        // synchroniser latency
        set_src(20'h00007);
        @(negedge clk);
        @(negedge clk); check("R4 not yet", {31'b0, irq_n[0]}, 32'h1);
        @(negedge clk); check("R4 at k+2", {31'b0, irq_n[0]}, 32'h0);
        rd_exp(0, 8'h04, "R3 rise src2");
        wr_reg(0, 8'h04);
        set_src(20'h0000F); idle(5);
        rd_exp(0, 8'h00, "R3 disabled src3");
        set_src(20'h0000D); idle(5);
        rd_exp(0, 8'h02, "R3 fall src1");
        wr_reg(0, 8'h02);

        // clear-on-read
        wr_reg(17, 8'h01);
        rd_exp(17, 8'h01, "R8 ctrl readback");
        set_src(20'h0000C); idle(5);
        set_src(20'h0000D); idle(5);
        wr_reg(0, 8'hFF);
        rd_exp(0, 8'h01, "R9 write ignored");
        rd_exp(0, 8'h00, "R9 read clears");
        rd_mod(6, "R5 line1 cor read");
        rd_exp(6, 8'h00, "R5 line1 cleared");

        // pending buffer on
        wr_reg(17, 8'h03);
        rd_exp(17, 8'h03, "R8 pending bit");
        set_src(20'h0000C); idle(4); set_src(20'h0000D); idle(4);
        set_src(20'h0000C); idle(4); set_src(20'h0000D); idle(4);
        rd_exp(0, 8'h01, "R11 first");
        rd_exp(0, 8'h01, "R11 reloaded");
        rd_exp(0, 8'h00, "R11 drained");
        rd_mod(6, "R11 line1 first");
        rd_mod(6, "R11 line1 second");

        // pending buffer off
        wr_reg(17, 8'h01);
        set_src(20'h0000C); idle(4); set_src(20'h0000D); idle(4);
        set_src(20'h0000C); idle(4); set_src(20'h0000D); idle(4);
        rd_exp(0, 8'h01, "R11 no buffer first");
        rd_exp(0, 8'h00, "R11 second lost");

        // event and clear in the same cycle
        set_src(20'h0000C); idle(4); set_src(20'h0000D); idle(4);
        set_src(20'h0000C); idle(4);
        set_src(20'h0000D);
        idle(1);
        rd_exp(0, 8'h01, "R12 read with event");
        rd_exp(0, 8'h01, "R12 event kept");
        rd_exp(0, 8'h00, "R12 then clear");

        // masks and line independence
        wr_reg(9, 8'hDF);
        set_src(20'h0002D); idle(5);
        check("R5 both lines", {30'b0, irq_n}, 32'h0);
        check("R7 prim l1", {24'b0, prim_l1}, 32'h4);
        wr_reg(3, 8'hFF);
        check("R6 masked line0", {31'b0, irq_n[0]}, 32'h1);
        rd_exp(0, 8'h20, "R6 status kept");
        rd_mod(6, "R5 line1 own status");
        check("R7 line1 released", {31'b0, irq_n[1]}, 32'h1);

        // top source, last bytes
        wr_reg(16, 8'h80);
        wr_reg(11, 8'h00);
        set_src(20'h8002D); idle(5);
        check("R7 src19 line1", {31'b0, irq_n[1]}, 32'h0);
        rd_exp(8, 8'h08, "R3 src19 line1");
        rd_exp(2, 8'h08, "R3 src19 line0");

        // out of range, bits above N
        wr_reg(20, 8'hFF);
        rd_exp(20, 8'h00, "R13 oor read");
        rd_exp(31, 8'h00, "R13 top addr");
        rd_exp(17, 8'h01, "R13 R8 ctrl unchanged");
        wr_reg(5, 8'h00);
        rd_exp(5, 8'h00, "R13 mask cleared");
        wr_reg(5, 8'hFF);
        rd_exp(5, 8'h0F, "R13 high bits zero");
        idle(3);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++; fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule